// File: doc/BRIEF.md
# SPI Serial EEPROM Command and Protection Controller

This block is the slave side of a serial memory: a 4096-byte, byte-addressed array that an external SPI master reads and programs. The controller runs on the chip clock and oversamples the serial clock, chip select and data-in lines through two-flop synchronizers. It accepts SPI modes 0 and 3. In both modes it samples data on the rising serial-clock edge and changes its output on the falling edge.

Each transaction starts with an opcode byte. The controller recognises six commands: read data, page write, set write-enable, clear write-enable, read status and write status. Programming is guarded in three ways. A write-enable latch must be set first. A two-bit lock field shields none, the top quarter, the top half or all of the array. A write-protect pin, combined with an enable bit in the status register, freezes the status register. A page write collects up to 32 bytes. It is committed when chip select rises on a byte boundary, and a self-timed programming cycle follows during which a busy bit is set.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and `spi_miso` is low while chip select is high.
- R2: Opcode 0x05 returns the status byte repeatedly until chip select rises. Its layout is: bit 0 busy, bit 1 write-enable latch, bits 3:2 lock field, bit 7 write-protect enable, bits 6:4 zero.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Each takes effect once the opcode byte is complete.
- R4: Opcode 0x03 is followed by two address bytes, whose low 12 bits (bits 11:8 of the first byte and all of the second) give the start address. Data bytes then stream out from consecutive addresses, and the address wraps from 0xFFF to 0x000. Opcode 0x02 with the same address format, followed by data bytes, programs those bytes.
- R5: A write or status-write opcode is ignored when the write-enable latch is clear. No cycle starts and the memory is unchanged.
- R6: During a page write, the byte address wraps within its aligned 32-byte page.
- R7: If chip select rises in the middle of a byte, nothing is committed. The memory stays unchanged, no busy cycle starts, and the write-enable latch keeps its value.
- R8: A commit sets the busy bit for exactly WRITE_CYCLES clock cycles. When busy clears, the write-enable latch clears at the same edge.
- R9: While busy, every opcode except 0x05 is ignored. Read data returns 0x00 bytes, and status writes have no effect.
- R10: Programmed bytes are dropped when they fall in the locked region. Lock value 01 covers 0xC00–0xFFF, 10 covers 0x800–0xFFF and 11 covers the whole array. Bytes outside the locked region are written.
- R11: Opcode 0x01 with a data byte updates only status bits 7 and 3:2, then runs a busy cycle.
- R12: When status bit 7 is set and `wp_n` is low, a status write is ignored and the write-enable latch stays set. With `wp_n` high the status write is accepted.
- R13: Every command behaves the same in SPI mode 3 (serial clock idling high) as in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock; everything is synchronous to its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, low while deselected |
| wp_n | input | 1 | Active-low write-protect pin for the status register |

## Verification
The end of the self-timed programming cycle can coincide with a status byte being loaded into the output shifter. The busy bit and the write-enable latch both change at that edge. The bench provokes this by holding one status-read transaction open right after a page commit and streaming status bytes until the block reports idle. Every streamed byte must be either 0x03 (busy with the latch set) or 0x00. The count of busy bytes must match the programmed cycle length, and any mixed value means the two bits were cleared on different edges.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    typedef enum logic [7:0] {
        OP_WRSR  = 8'h01,
        OP_WRITE = 8'h02,
        OP_READ  = 8'h03,
        OP_WRDI  = 8'h04,
        OP_RDSR  = 8'h05,
        OP_WREN  = 8'h06
    } opcode_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADH,
        PH_ADL,
        PH_RDAT,
        PH_WDAT,
        PH_SDAT,
        PH_RSTAT,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       wp_en;
        logic [2:0] zero;
        logic [1:0] lock;
        logic       wel;
        logic       wip;
    } stat_t;

    // top2: the two most significant address bits of the target byte
    function automatic logic lock_hit(input logic [1:0] top2, input logic [1:0] lock);
        case (lock)
            2'b00:   return 1'b0;
            2'b01:   return (top2 == 2'b11);
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_next,
    output logic       miso,
    output logic       sel,
    output logic       sel_rise,
    output logic       sel_fall,
    output logic       aligned,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    logic [1:0] sck_m, cs_m, mosi_m;
    logic       sck_d, sel_d;
    logic [2:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [7:0] tx_sh;
    logic       rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_m  <= 2'b00;
            cs_m   <= 2'b11;
            mosi_m <= 2'b00;
            sck_d  <= 1'b0;
            sel_d  <= 1'b0;
        end else begin
            sck_m  <= {sck_m[0], sck};
            cs_m   <= {cs_m[0], cs_n};
            mosi_m <= {mosi_m[0], mosi};
            sck_d  <= sck_m[1];
            sel_d  <= sel;
        end
    end

    assign sel      = ~cs_m[1];
    assign rise     = sck_m[1] & ~sck_d;
    assign fall     = ~sck_m[1] & sck_d;
    assign sel_rise = sel & ~sel_d;
    assign sel_fall = ~sel & sel_d;
    assign aligned  = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= 3'd0;
            rx_sh   <= 7'd0;
            tx_sh   <= 8'd0;
        end else if (rise) begin
            rx_sh   <= {rx_sh[5:0], mosi_m[1]};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) tx_sh <= tx_next;
        end else if (fall && bit_cnt != 3'd0) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
        end
    end

    assign byte_done = sel & rise & (bit_cnt == 3'd7);
    assign rx_byte   = {rx_sh, mosi_m[1]};
    assign miso      = sel & tx_sh[7];
endmodule

// File: rtl/spi_ee_timer.sv
module spi_ee_timer #(
    parameter int WRITE_CYCLES = 250000,
    parameter int STEPS        = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(STEPS)-1:0] step,
    output logic                     step_valid
);
    localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);
    localparam int STEP_W = $clog2(STEPS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (done) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign done       = busy && (cnt == CNT_W'(WRITE_CYCLES - 1));
    assign step       = cnt[STEP_W-1:0];
    assign step_valid = busy && (cnt < CNT_W'(STEPS));
endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    input  logic wp_n
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int HI_W   = ADDR_W - 8;

    logic             sel, sel_rise, sel_fall, aligned, byte_done;
    logic [7:0]       rx_byte, tx_next, rd_data;
    logic             wr_busy, wr_done, step_valid;
    logic [OFF_W-1:0] step;

    phase_e            phase;
    logic [HI_W-1:0]   addr_hi;
    logic              is_wr;
    logic [ADDR_W-1:0] rd_ptr, a_now, rd_addr, mem_waddr;
    logic [PAGE_W-1:0] page_idx;
    logic [OFF_W-1:0]  off;
    logic [7:0]        pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic              got, cyc_page;
    logic              s_wpen;
    logic [1:0]        s_lock;
    logic              wel_q, wpen_q;
    logic [1:0]        lock_q;
    logic [1:0]        w_top2;
    logic              mem_we, commit_page, commit_stat;
    stat_t             st;

    spi_ee_shift u_shift (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_next(tx_next), .miso(spi_miso), .sel(sel), .sel_rise(sel_rise),
        .sel_fall(sel_fall), .aligned(aligned), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    spi_ee_timer #(.WRITE_CYCLES(WRITE_CYCLES), .STEPS(PAGE_BYTES)) u_timer (
        .clk(clk), .rst(rst), .start(commit_page | commit_stat), .busy(wr_busy),
        .done(wr_done), .step(step), .step_valid(step_valid)
    );

    spi_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pbuf[step]),
        .raddr(rd_addr), .rdata(rd_data)
    );

    always_comb begin
        st.wp_en = wpen_q;
        st.zero  = 3'b000;
        st.lock  = lock_q;
        st.wel   = wel_q;
        st.wip   = wr_busy;
    end

    assign a_now       = {addr_hi, rx_byte};
    assign rd_addr     = (phase == PH_ADL) ? a_now : rd_ptr;
    assign mem_waddr   = {page_idx, step};
    assign w_top2      = mem_waddr[ADDR_W-1 -: 2];
    assign mem_we      = step_valid && cyc_page && pmask[step] && !lock_hit(w_top2, lock_q);
    assign commit_page = sel_fall && aligned && got && (phase == PH_WDAT);
    assign commit_stat = sel_fall && aligned && got && (phase == PH_SDAT);

    always_comb begin
        tx_next = 8'h00;
        case (phase)
            PH_OPC:   if (rx_byte == OP_RDSR) tx_next = st;
            PH_RSTAT: tx_next = st;
            PH_ADL:   if (!is_wr) tx_next = rd_data;
            PH_RDAT:  tx_next = rd_data;
            default:  tx_next = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (byte_done && phase == PH_WDAT) pbuf[off] <= rx_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPC;
            addr_hi  <= '0;
            is_wr    <= 1'b0;
            rd_ptr   <= '0;
            page_idx <= '0;
            off      <= '0;
            pmask    <= '0;
            got      <= 1'b0;
            cyc_page <= 1'b0;
            s_wpen   <= 1'b0;
            s_lock   <= 2'b00;
            wel_q    <= 1'b0;
            wpen_q   <= 1'b0;
            lock_q   <= 2'b00;
        end else begin
            if (wr_done) wel_q <= 1'b0;
            if (commit_stat) begin
                lock_q   <= s_lock;
                wpen_q   <= s_wpen;
                cyc_page <= 1'b0;
            end
            if (commit_page) cyc_page <= 1'b1;
            if (sel_rise || sel_fall) begin
                phase <= PH_OPC;
            end else if (byte_done) begin
                case (phase)
                    PH_OPC: begin
                        got   <= 1'b0;
                        phase <= PH_SKIP;
                        if (rx_byte == OP_RDSR) begin
                            phase <= PH_RSTAT;
                        end else if (!wr_busy) begin
                            case (rx_byte)
                                OP_WREN:  wel_q <= 1'b1;
                                OP_WRDI:  wel_q <= 1'b0;
                                OP_READ:  begin is_wr <= 1'b0; phase <= PH_ADH; end
                                OP_WRITE: if (wel_q) begin is_wr <= 1'b1; phase <= PH_ADH; end
                                OP_WRSR:  if (wel_q && !(wpen_q && !wp_n)) phase <= PH_SDAT;
                                default:  ;
                            endcase
                        end
                    end
                    PH_ADH: begin
                        addr_hi <= rx_byte[HI_W-1:0];
                        phase   <= PH_ADL;
                    end
                    PH_ADL: begin
                        if (is_wr) begin
                            page_idx <= a_now[ADDR_W-1:OFF_W];
                            off      <= a_now[OFF_W-1:0];
                            pmask    <= '0;
                            phase    <= PH_WDAT;
                        end else begin
                            rd_ptr <= a_now + ADDR_W'(1);
                            phase  <= PH_RDAT;
                        end
                    end
                    PH_RDAT: rd_ptr <= rd_ptr + ADDR_W'(1);
                    PH_WDAT: begin
                        pmask[off] <= 1'b1;
                        off        <= off + OFF_W'(1);
                        got        <= 1'b1;
                    end
                    PH_SDAT: begin
                        s_wpen <= rx_byte[7];
                        s_lock <= rx_byte[3:2];
                        got    <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       wel,
    input logic [1:0] lock,
    input logic       mem_we,
    input logic [1:0] top2
);
    // R8: the latch is gone at the edge where busy drops
    p_wel_drop_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R8: the array is written only inside a timed cycle
    p_mem_busy_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R9: the latch cannot be set while busy
    p_wel_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(wel) |-> !busy);

    // R10: no write lands in the locked region
    p_lock_write_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !spi_ee_pkg::lock_hit(top2, lock));

    // R11: the lock field changes only when the latch was set
    p_lock_wel_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(lock) |-> $past(wel));
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .busy(wr_busy), .wel(wel_q), .lock(lock_q),
    .mem_we(mem_we), .top2(w_top2)
);

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;
    localparam int WC   = 1500;
    localparam int HALF = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
    logic miso;

    always #10 clk = ~clk;

    spi_eeprom_ctrl #(.ADDR_W(12), .PAGE_BYTES(32), .WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .wp_n(wp_n)
    );

    int n_tests = 0, n_fail = 0;
    bit mode3 = 1'b0, finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        logic [7:0] a, e;
        string t;
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(a, e, t);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            tick(HALF);
            rx[i] = miso;
            sck = 1'b1;
            tick(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        spi_byte(b, r, 8);
    endtask

    task automatic cs_on();
        sck = mode3;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic cs_off();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic expect_push(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic wren(); cs_on(); send(8'h06); cs_off(); endtask
    task automatic wrdi(); cs_on(); send(8'h04); cs_off(); endtask
    task automatic wrsr(input logic [7:0] v); cs_on(); send(8'h01); send(v); cs_off(); endtask
    task automatic settle(); tick(WC + 40); endtask

    task automatic do_write(input logic [11:0] a, input int n, input logic [63:0] d);
        cs_on();
        send(8'h02); send({4'h0, a[11:8]}); send(a[7:0]);
        for (int i = 0; i < n; i++) send(d[63 - 8 * i -: 8]);
        cs_off();
    endtask

    task automatic do_read(input logic [11:0] a, input int n, input logic [63:0] d, input string tag);
        logic [7:0] r;
        cs_on();
        send(8'h03); send({4'h0, a[11:8]}); send(a[7:0]);
        for (int i = 0; i < n; i++) begin
            expect_push(d[63 - 8 * i -: 8], tag);
            spi_byte(8'h00, r, 8);
            act_q.push_back(r);
        end
        cs_off();
    endtask

    task automatic rdsr(input logic [7:0] e, input string tag);
        logic [7:0] r;
        cs_on();
        send(8'h05);
        expect_push(e, tag);
        spi_byte(8'h00, r, 8);
        act_q.push_back(r);
        cs_off();
    endtask

    // stream status through one transaction across the end of a busy cycle
    task automatic busy_stream();
        logic [7:0] r, first;
        int busy_bytes = 0;
        bit idle = 1'b0, odd = 1'b0;
        cs_on();
        send(8'h05);
        for (int k = 0; k < 40 && !idle; k++) begin
            spi_byte(8'h00, r, 8);
            if (k == 0) first = r;
            if (r == 8'h03) busy_bytes++;
            else if (r == 8'h00) idle = 1'b1;
            else odd = 1'b1;
        end
        cs_off();
        chk(first, 8'h03, "R8 busy and latch set right after commit");
        chk({7'd0, odd}, 8'h00, "R8 only 03 or 00 seen while cycle ends");
        chk({7'd0, idle}, 8'h01, "R8 busy clears");
        chk({7'd0, busy_bytes >= 10 && busy_bytes <= 12}, 8'h01, "R8 busy length");
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        tick(5);
        rst = 1'b0;
        tick(5);
        chk({7'd0, miso}, 8'h00, "R1 miso low when deselected");
        rdsr(8'h00, "R1 R2 status after reset");

        wren();  rdsr(8'h02, "R3 latch set");
        wrdi();  rdsr(8'h00, "R3 latch cleared");

        wren();
        do_write(12'h010, 4, 64'h11223344_00000000);
        busy_stream();
        rdsr(8'h00, "R8 latch cleared after cycle");
        do_read(12'h010, 4, 64'h11223344_00000000, "R4 sequential read");

        do_write(12'h010, 1, 64'hAA000000_00000000);
        rdsr(8'h00, "R5 no cycle without latch");
        do_read(12'h010, 1, 64'h11000000_00000000, "R5 memory unchanged");

        wren(); do_write(12'h03E, 5, 64'hA0A1A2A3_A4000000); settle();
        do_read(12'h03E, 2, 64'hA0A10000_00000000, "R6 page tail");
        do_read(12'h020, 3, 64'hA2A3A400_00000000, "R6 wrapped to page start");

        wren(); do_write(12'hFFF, 2, 64'h5A6B0000_00000000); settle();
        wren(); do_write(12'h000, 1, 64'hA5000000_00000000); settle();
        do_read(12'hFFF, 2, 64'h5AA50000_00000000, "R4 read wraps past top");
        do_read(12'hFE0, 1, 64'h6B000000_00000000, "R6 wrap at top page");

        wren();
        cs_on();
        send(8'h02); send(8'h00); send(8'h10); send(8'hEE);
        spi_byte(8'hFF, r, 4);
        cs_off();
        rdsr(8'h02, "R7 no cycle and latch kept");
        do_read(12'h010, 1, 64'h11000000_00000000, "R7 memory unchanged");
        wrdi();

        wren(); do_write(12'h050, 1, 64'h77000000_00000000);
        do_read(12'h010, 2, 64'h0, "R9 read ignored while busy");
        wrsr(8'h0C);
        settle();
        rdsr(8'h00, "R9 status write ignored while busy");
        do_read(12'h050, 1, 64'h77000000_00000000, "R9 pending write completed");

        wren(); do_write(12'hBFF, 1, 64'hB1000000_00000000); settle();
        wren(); do_write(12'hC00, 1, 64'hC1000000_00000000); settle();
        wrsr(8'h04);
        rdsr(8'h00, "R11 status write needs latch");
        wren(); wrsr(8'h04); settle();
        rdsr(8'h04, "R11 lock field quarter");
        wren(); do_write(12'hC00, 1, 64'hEE000000_00000000); settle();
        do_read(12'hC00, 1, 64'hC1000000_00000000, "R10 top quarter protected");
        wren(); do_write(12'hBFF, 1, 64'hEE000000_00000000); settle();
        do_read(12'hBFF, 1, 64'hEE000000_00000000, "R10 below quarter writable");

        wren(); wrsr(8'h08); settle();
        wren(); do_write(12'hBFF, 1, 64'hD1000000_00000000); settle();
        do_read(12'hBFF, 1, 64'hEE000000_00000000, "R10 top half protected");
        wren(); do_write(12'h010, 1, 64'h12000000_00000000); settle();
        do_read(12'h010, 1, 64'h12000000_00000000, "R10 lower half writable");

        wren(); wrsr(8'hFF); settle();
        rdsr(8'h8C, "R11 only bits 7 and 3:2 written");
        wren(); do_write(12'h000, 1, 64'h00000000_00000000); settle();
        do_read(12'h000, 1, 64'hA5000000_00000000, "R10 whole array protected");

        wp_n = 1'b0;
        wren(); wrsr(8'h00); settle();
        rdsr(8'h8E, "R12 pin low blocks status write");
        wp_n = 1'b1;
        wrsr(8'h00); settle();
        rdsr(8'h00, "R12 accepted with pin high");

        mode3 = 1'b1;
        sck = 1'b1;
        tick(20);
        rdsr(8'h00, "R13 mode 3 status");
        wren(); rdsr(8'h02, "R13 mode 3 latch");
        do_write(12'h100, 2, 64'h3CC30000_00000000); settle();
        do_read(12'h100, 2, 64'h3CC30000_00000000, "R13 mode 3 readback");

        tick(50);
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d unmatched expected 0", exp_q.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule